// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on one byte that holds two packed BCD digits. It supports three operations: add with extend, subtract with extend, and negate with extend. Each operation takes the incoming extend bit into account, so a caller can chain bytes from the least significant to the most significant and get a decimal result of any length. Along with the result byte, the unit returns the new negative, zero, overflow, carry and extend flags. It also returns a write enable that tells the caller whether the destination should be updated.

The operands arrive already fetched. The caller presents them with a one-cycle start strobe, together with the previous extend and zero flags. One clock later the registered result, write enable and flags appear, and a one-cycle done pulse marks them. Between operations the outputs hold their values. Memory addressing, bus access and opcode decoding are left to the surrounding logic.

The zero flag is designed for multi-byte chains. The unit never sets it, and it only clears it when a byte comes out nonzero. A caller therefore seeds the flag with 1 before the first byte and reads it after the last byte to learn whether the whole decimal number was zero.

Top module: `bcd_byte_alu`

## Requirements
- R1: Add (op_i = 2'b00) works as follows:
  - Form `u = src[3:0] + dst[3:0] + x_i`, and add 6 to `u` if it exceeds 9.
  - Add both high digits, each weighted by 16, to get `t`.
  - If `t` exceeds 0x99, subtract 0xA0 and set C and X. Otherwise C and X are cleared.
  - result_o is the low byte of `t`, and wr_en_o is 1.
- R2: Subtract (op_i = 2'b01) works as follows:
  - Form `u = dst[3:0] - src[3:0] - x_i`, and subtract 6 from `u` if it is negative or exceeds 9.
  - Add the destination high digit times 16 and subtract the source high digit times 16, giving `t`.
  - If `t` is negative or exceeds 0x99, add 0xA0 and set C and X. Otherwise C and X are cleared.
  - result_o is the low byte of `t`, and wr_en_o is 1.
- R3: Negate (op_i = 2'b10) works as follows:
  - Form `t = (0x9A - dst - x_i) mod 256`.
  - When `t` is not 0x9A and its low digit equals 0xA, the low digit is cleared and 0x10 is added modulo 256.
  - The result is written (wr_en_o = 1) and C and X are set.
- R4: Negate with `t` equal to 0x9A gives wr_en_o = 0, clears C and X, leaves Z equal to z_i, sets N = 0, and returns result_o equal to dst_i.
- R5: For every written result, z_o is z_i AND (result byte equal to 0). No operation ever sets Z from 0 to 1.
- R6: On every completed operation, n_o equals bit 7 of the written result (0 when nothing is written) and v_o is 0.
- R7: On every completed operation, c_o equals x_o, except for reserved selects.
- R8: op_i = 2'b11 gives wr_en_o = 0, result_o = dst_i, n_o = c_o = v_o = 0, x_o = x_i and z_o = z_i.
- R9: Outputs update on the clock edge that samples start_i high, and done_o is high for exactly the following cycle. Without start_i, all outputs except done_o hold their values and done_o is 0.
- R10: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe, one cycle |
| op_i | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| src_i | input | 8 | Source byte, two packed BCD digits |
| dst_i | input | 8 | Destination byte, two packed BCD digits |
| x_i | input | 1 | Incoming extend flag |
| z_i | input | 1 | Incoming zero flag from the previous byte |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Destination should be written |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| c_o | output | 1 | Carry/borrow flag |
| x_o | output | 1 | Extend flag |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest cases to reach are the decimal corrections on bytes that are not valid BCD, and the wraparound equality in negate. In that wraparound case, a destination of 0xFF with extend set produces no write, just as zero with extend clear does. To cover both, the stimulus sweeps every source and destination pair for add and subtract, and every destination with both extend values for negate. The incoming extend and zero bits are derived from operand bits, so that carry-in, sticky-zero retention and zero clearing each occur many times. Idle cycles are inserted between operations to confirm that the outputs hold.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 2 * DIGIT_W;
  localparam int WIDE_W  = BYTE_W + 2;

  localparam logic [BYTE_W-1:0] DIG_MAX   = 8'h09;
  localparam logic [BYTE_W-1:0] DIG_ADJ   = 8'h06;
  localparam logic [BYTE_W-1:0] BYTE_MAX  = 8'h99;
  localparam logic [BYTE_W-1:0] TENS_ADJ  = 8'hA0;
  localparam logic [BYTE_W-1:0] NEG_BASE  = 8'h9A;
  localparam logic [DIGIT_W-1:0] NEG_DIG  = 4'hA;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              wr;
    logic              n;
    logic              z;
    logic              v;
    logic              c;
    logic              x;
  } bcd_out_t;
endpackage

// File: rtl/bcd_add_unit.sv
module bcd_add_unit
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              x_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              carry_o
);
  logic [WIDE_W-1:0] units, total;

  always_comb begin
    units = WIDE_W'(a_i[DIGIT_W-1:0]) + WIDE_W'(b_i[DIGIT_W-1:0]) + WIDE_W'(x_i);
    if (units > WIDE_W'(DIG_MAX)) units = units + WIDE_W'(DIG_ADJ);
    total = units + WIDE_W'({a_i[BYTE_W-1:DIGIT_W], {DIGIT_W{1'b0}}})
                  + WIDE_W'({b_i[BYTE_W-1:DIGIT_W], {DIGIT_W{1'b0}}});
    carry_o = total > WIDE_W'(BYTE_MAX);
    res_o   = carry_o ? total[BYTE_W-1:0] - TENS_ADJ : total[BYTE_W-1:0];
  end
endmodule

// File: rtl/bcd_sub_unit.sv
module bcd_sub_unit
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] sub_i,
  input  logic              x_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              borrow_o
);
  logic [WIDE_W-1:0] units, total;

  // two's complement in WIDE_W: negative values compare above any legal byte
  always_comb begin
    units = WIDE_W'(min_i[DIGIT_W-1:0]) - WIDE_W'(sub_i[DIGIT_W-1:0]) - WIDE_W'(x_i);
    if (units > WIDE_W'(DIG_MAX)) units = units - WIDE_W'(DIG_ADJ);
    total = units + WIDE_W'({min_i[BYTE_W-1:DIGIT_W], {DIGIT_W{1'b0}}})
                  - WIDE_W'({sub_i[BYTE_W-1:DIGIT_W], {DIGIT_W{1'b0}}});
    borrow_o = total > WIDE_W'(BYTE_MAX);
    res_o    = borrow_o ? total[BYTE_W-1:0] + TENS_ADJ : total[BYTE_W-1:0];
  end
endmodule

// File: rtl/bcd_neg_unit.sv
module bcd_neg_unit
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] d_i,
  input  logic              x_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              wr_o
);
  logic [BYTE_W-1:0] raw;

  always_comb begin
    raw  = NEG_BASE - d_i - BYTE_W'(x_i);
    wr_o = raw != NEG_BASE;
    if (raw[DIGIT_W-1:0] == NEG_DIG)
      res_o = {raw[BYTE_W-1:DIGIT_W] + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    else
      res_o = raw;
  end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [BYTE_W-1:0] src_i,
  input  logic [BYTE_W-1:0] dst_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic [BYTE_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              x_o,
  output logic              done_o
);
  logic [BYTE_W-1:0] add_res, sub_res, neg_res;
  logic              add_c, sub_c, neg_wr;
  bcd_op_e           op_e;
  bcd_out_t          nxt, cur;
  logic              done_q;

  bcd_add_unit u_add (.a_i(src_i), .b_i(dst_i), .x_i(x_i), .res_o(add_res), .carry_o(add_c));
  bcd_sub_unit u_sub (.min_i(dst_i), .sub_i(src_i), .x_i(x_i), .res_o(sub_res), .borrow_o(sub_c));
  bcd_neg_unit u_neg (.d_i(dst_i), .x_i(x_i), .res_o(neg_res), .wr_o(neg_wr));

  assign op_e = bcd_op_e'(op_i);

  always_comb begin
    nxt     = '0;
    nxt.res = dst_i;
    nxt.x   = x_i;
    nxt.z   = z_i;
    unique case (op_e)
      OP_ADD: begin
        nxt.res = add_res;
        nxt.wr  = 1'b1;
        nxt.c   = add_c;
        nxt.x   = add_c;
      end
      OP_SUB: begin
        nxt.res = sub_res;
        nxt.wr  = 1'b1;
        nxt.c   = sub_c;
        nxt.x   = sub_c;
      end
      OP_NEG: begin
        nxt.x = neg_wr;
        nxt.c = neg_wr;
        if (neg_wr) begin
          nxt.res = neg_res;
          nxt.wr  = 1'b1;
        end
      end
      default: ;
    endcase
    if (nxt.wr) begin
      nxt.n = nxt.res[BYTE_W-1];
      nxt.z = z_i & (nxt.res == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) cur <= nxt;
    end
  end

  assign result_o = cur.res;
  assign wr_en_o  = cur.wr;
  assign n_o      = cur.n;
  assign z_o      = cur.z;
  assign v_o      = cur.v;
  assign c_o      = cur.c;
  assign x_o      = cur.x;
  assign done_o   = done_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R9
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && $stable(result_o) && $stable(z_o)); // R9
  AST_Z_NEVER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !z_i) |=> !z_o); // R5
  AST_CARRY_MATCHES_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i != 2'b11) |=> c_o == x_o); // R7
  AST_RSV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b11) |=> !wr_en_o && result_o == $past(dst_i)); // R8
  AST_ADD_DIGITS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b00 && src_i[3:0] <= 4'd9 && src_i[7:4] <= 4'd9
     && dst_i[3:0] <= 4'd9 && dst_i[7:4] <= 4'd9)
    |=> result_o[3:0] <= 4'd9 && result_o[7:4] <= 4'd9); // R1
  AST_NEG_SKIP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b10 && dst_i == 8'h00 && !x_i) |=> !wr_en_o && !c_o && !x_o); // R4
endmodule

// File: tb/tb_bcd_byte_alu.sv
module tb_bcd_byte_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] src = 8'h00, dst = 8'h00;
  logic       xin = 1'b0, zin = 1'b0;
  logic [7:0] result;
  logic       wr_en, n, z, v, c, x, done;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  bcd_byte_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .src_i(src), .dst_i(dst),
    .x_i(xin), .z_i(zin), .result_o(result), .wr_en_o(wr_en), .n_o(n), .z_o(z),
    .v_o(v), .c_o(c), .x_o(x), .done_o(done)
  );

  int    e_res = 0, e_wr = 0, e_n = 0, e_z = 0, e_c = 0, e_x = 0, e_done = 0;
  string e_tag = "R10";
  bit    pending = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk({e_tag, " result"}, int'(result), e_res);
    chk({e_tag, " wr_en"}, int'(wr_en), e_wr);
    chk("R5 zero", int'(z), e_z);
    chk("R6 neg/ovf", int'({n, v}), e_n * 2);
    chk("R7 carry/ext", int'({c, x}), e_c * 2 + e_x);
    chk("R9 done", int'(done), e_done);
  endtask

  // behavioural reference from the digit rules
  task automatic model(input int o, input int s, input int d, input int xi, input int zi);
    int u, t, cy;
    e_done = 1;
    e_res = d; e_wr = 0; e_n = 0; e_c = 0; e_x = xi; e_z = zi;
    if (o == 0) begin
      u = (s % 16) + (d % 16) + xi;
      if (u > 9) u += 6;
      t = u + (s / 16) * 16 + (d / 16) * 16;
      cy = (t > 153) ? 1 : 0;
      if (cy == 1) t -= 160;
      e_res = t & 255; e_wr = 1; e_c = cy; e_x = cy; e_tag = "R1";
    end else if (o == 1) begin
      u = (d % 16) - (s % 16) - xi;
      if (u < 0 || u > 9) u -= 6;
      t = u + (d / 16) * 16 - (s / 16) * 16;
      cy = (t < 0 || t > 153) ? 1 : 0;
      if (cy == 1) t += 160;
      e_res = t & 255; e_wr = 1; e_c = cy; e_x = cy; e_tag = "R2";
    end else if (o == 2) begin
      t = (154 - d - xi) & 255;
      if (t == 154) begin
        e_c = 0; e_x = 0; e_tag = "R4";
      end else begin
        if ((t % 16) == 10) t = ((t / 16) * 16 + 16) & 255;
        e_res = t; e_wr = 1; e_c = 1; e_x = 1; e_tag = "R3";
      end
    end else begin
      e_tag = "R8";
    end
    if (e_wr == 1) begin
      e_n = (e_res >= 128) ? 1 : 0;
      e_z = (zi == 1 && e_res == 0) ? 1 : 0;
    end
  endtask

  task automatic step(input bit st, input int o, input int s, input int d, input int xi, input int zi);
    @(negedge clk);
    if (pending) compare();
    start = st; op = 2'(o); src = 8'(s); dst = 8'(d); xin = xi[0]; zin = zi[0];
    if (st) model(o, s, d, xi, zi);
    else begin
      e_done = 0; e_tag = "R9";
    end
    pending = 1;
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (2) @(negedge clk);
    chk("R10 reset outputs", int'({result, wr_en, n, z, v, c, x, done}), 0);
    rst_n = 1'b1;

    for (int s = 0; s < 256; s++)
      for (int d = 0; d < 256; d++)
        for (int o = 0; o < 2; o++)
          step(1, o, s, d, (s ^ (d >> 1)) & 1, ((d >> 3) ^ s) & 1 | ((s + d) % 7 == 0 ? 1 : 0));

    for (int d = 0; d < 256; d++)
      for (int xi = 0; xi < 2; xi++) begin
        step(1, 2, d ^ 8'h5A, d, xi, (d >> 2) & 1);
        if ((d % 16) == 0) step(0, 3, 8'h11, 8'h22, 1, 0);
      end

    // multi-byte chain: 0x0000 + 0x0000 keeps Z, then a nonzero byte clears it
    step(1, 0, 8'h00, 8'h00, 0, 1);
    step(1, 0, 8'h00, 8'h00, 0, 1);
    step(1, 1, 8'h01, 8'h01, 0, 1);
    step(1, 1, 8'h00, 8'h01, 0, 1);

    for (int k = 0; k < 8; k++) begin
      step(1, 3, k * 31, k * 17 + 3, k & 1, (k >> 1) & 1);
      step(0, 0, 8'h99, 8'h99, 1, 1);
    end
    step(1, 2, 8'h00, 8'hFF, 1, 1);
    step(1, 0, 8'h99, 8'h99, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule